// File: doc/BRIEF.md
# Oversampled Spread-Spectrum Despreader

This block recovers data bits from a hard-decision chip stream that has already been sliced to single bits. Each chip arrives as four consecutive samples. A sample strobe marks every sample. The block keeps a sliding window of the most recent samples. At every sample it compares the chips of that window with a programmable spreading code. When the number of agreeing chips reaches a programmable threshold, it takes the window as a data 1. When the number of disagreeing chips reaches the threshold, it takes the window as a data 0. Windows that meet neither condition are treated as noise and produce no data.

Three decoding modes are available. The long mode spreads one bit over 64 chips. The short mode spreads one bit over 32 chips. The paired mode carries two bits in each 32-chip period, one bit in each 16-chip half.

The first accepted window sets the bit timing. After that, the next window is only taken one code period later, with one sample of slack either way. If no window is taken inside that slack, the block drops back to searching and throws away the byte it was building. Recovered bits are packed into bytes, first bit in the most significant position. Each completed byte is presented with a one-clock strobe, and each accepted window raises a one-clock correlation flag.

Top module: `despread_correlator`

## Requirements
- R1: While `rst` is high, `byte_valid` and `corr_valid` are 0 and `byte_data` is 0.
- R2: Long mode (`mode`=0, or 3): the window holds 64 chips. The chip received first is compared with `pn_code[63]` and the chip received last with `pn_code[0]`. If at least `threshold` chips agree, the window is a 1. Otherwise, if at least `threshold` chips disagree, it is a 0. A 1 is tested before a 0.
- R3: Short mode (`mode`=1): the window holds 32 chips. They are compared with `pn_code[31:0]`, the first chip received against bit 31. The rule of R2 applies over 32 chips.
- R4: Paired mode (`mode`=2): a 32-chip window yields two bits. The first 16 chips received are compared with `pn_code[31:16]` and give the earlier bit. The last 16 chips are compared with `pn_code[15:0]` and give the later bit. Each half uses the R2 rule over 16 chips with threshold floor(`threshold`/2). The window is taken only if both halves decide.
- R5: A window that meets neither polarity's threshold is ignored. It raises no `corr_valid` and adds no bit to the byte being assembled.
- R6: Each chip spans 4 samples. A window is evaluated after every sample, and the window uses every 4th sample counting back from the newest. A window therefore becomes complete on the first sample of its last chip.
- R7: After a window is taken, the next window is taken only at 1 code period ±1 sample after it. The code period is 256 samples in long mode and 128 in short and paired modes. Windows at any other offset are not taken.
- R8: If no window is taken by 1 code period + 1 sample, the block returns to searching, where a window is taken at any sample. The partly assembled byte is discarded.
- R9: Bits are packed MSB first, 8 to a byte. `byte_valid` is high for exactly one clock with the finished byte on `byte_data`. `byte_data` holds its value until the next byte.
- R10: `corr_valid` pulses for one clock for each window taken. It is high on the second clock edge after the edge that accepts the completing sample.
- R11: Clocks without `sample_valid` leave the window, the timing and the byte state unchanged, so gaps between samples do not alter the recovered data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | A new sample is present on `sample_in` |
| sample_in | input | 1 | Hard-sliced chip sample |
| mode | input | 2 | 0 long, 1 short, 2 paired, 3 as long; hold stable while running |
| pn_code | input | 64 | Spreading code; bit 63 is sent first in long mode |
| threshold | input | 7 | Minimum agreeing (or disagreeing) chip count |
| byte_data | output | 8 | Last completed byte |
| byte_valid | output | 1 | One-clock strobe for a new byte |
| corr_valid | output | 1 | One-clock strobe for each window taken |

## Verification
Clean streams are sent in every mode, with byte values that mix runs of ones, runs of zeros and alternating bits. A match in these streams shows that code order, polarity and packing order are right.

Chips are deliberately flipped so that the count lands exactly on the threshold and then one short of it, which pins the comparison at its edge. In paired mode the flips go into one half only, to show that each half is judged on its own.

Random sample noise must produce nothing. A single sample inserted or removed between bits must be tracked. Two inserted samples must break lock and restart byte assembly, and the bytes that follow show exactly where assembly restarted. A stream with idle clocks between samples must decode the same as a dense one, and a partial-window probe pins the clock on which the flag appears.

// File: rtl/despread_pkg.sv
package despread_pkg;

    // Decoding mode as seen on the mode pins.
    typedef enum logic [1:0] {
        MODE_LONG  = 2'd0,
        MODE_SHORT = 2'd1,
        MODE_PAIR  = 2'd2,
        MODE_ALT   = 2'd3
    } chip_mode_e;

    // Bit timing tracker states.
    typedef enum logic {
        TRK_SEARCH = 1'b0,
        TRK_LOCKED = 1'b1
    } trk_state_e;

    // Outcome of one window evaluation.
    typedef struct packed {
        logic       hit;    // window decided
        logic       pair;   // two bits carried
        logic [1:0] bits;   // [1] earlier bit, [0] later bit (single: [0])
    } decision_t;

    // Judge one correlation: returns {decided, value}.
    function automatic logic [1:0] judge(input int agree, input int len, input int thr);
        if (agree >= thr)
            return 2'b11;
        if ((len - agree) >= thr)
            return 2'b10;
        return 2'b00;
    endfunction

endpackage

// File: rtl/despread_window.sv
module despread_window #(
    parameter int OSR       = 4,
    parameter int MAX_CHIPS = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sample_valid,
    input  logic                 sample_in,
    output logic [MAX_CHIPS-1:0] chips,
    output logic                 win_new
);
    localparam int DEPTH = OSR * MAX_CHIPS;

    // taps[0] is the newest sample
    logic [DEPTH-1:0] taps;

    always_ff @(posedge clk) begin
        if (rst) begin
            taps    <= '0;
            win_new <= 1'b0;
        end else begin
            win_new <= sample_valid;
            if (sample_valid)
                taps <= {taps[DEPTH-2:0], sample_in};
        end
    end

    // chips[j] is the j-th newest chip, one sample per chip
    for (genvar j = 0; j < MAX_CHIPS; j++) begin : g_decimate
        assign chips[j] = taps[j*OSR];
    end

endmodule

// File: rtl/despread_corr.sv
module despread_corr
    import despread_pkg::*;
#(
    parameter int MAX_CHIPS = 64,
    parameter int THR_W     = $clog2(MAX_CHIPS + 1)
) (
    input  logic [MAX_CHIPS-1:0] chips,
    input  logic [MAX_CHIPS-1:0] code,
    input  logic [THR_W-1:0]     thr,
    input  chip_mode_e           mode,
    output decision_t            dec
);
    localparam int HALF = MAX_CHIPS / 2;
    localparam int QTR  = MAX_CHIPS / 4;
    localparam int CW   = $clog2(MAX_CHIPS + 1);

    logic [MAX_CHIPS-1:0] agree;
    logic [CW-1:0] cnt_full, cnt_short, cnt_lo, cnt_hi;
    logic [1:0]    j_full, j_short, j_lo, j_hi;
    logic [THR_W-1:0] thr_half;

    assign agree    = ~(chips ^ code);
    assign thr_half = thr >> 1;

    // agreement counts over the nested windows
    always_comb begin
        cnt_full  = '0;
        cnt_short = '0;
        cnt_lo    = '0;
        cnt_hi    = '0;
        for (int i = 0; i < MAX_CHIPS; i++) begin
            cnt_full = cnt_full + CW'(agree[i]);
            if (i < QTR)
                cnt_lo = cnt_lo + CW'(agree[i]);
            else if (i < HALF)
                cnt_hi = cnt_hi + CW'(agree[i]);
            if (i < HALF)
                cnt_short = cnt_short + CW'(agree[i]);
        end
    end

    assign j_full  = judge(int'(cnt_full),  MAX_CHIPS, int'(thr));
    assign j_short = judge(int'(cnt_short), HALF,      int'(thr));
    assign j_hi    = judge(int'(cnt_hi),    QTR,       int'(thr_half));
    assign j_lo    = judge(int'(cnt_lo),    QTR,       int'(thr_half));

    always_comb begin
        dec = '0;
        unique case (mode)
            MODE_SHORT: begin
                dec.hit  = j_short[1];
                dec.bits = {1'b0, j_short[0]};
            end
            MODE_PAIR: begin
                dec.hit  = j_hi[1] & j_lo[1];
                dec.pair = 1'b1;
                dec.bits = {j_hi[0], j_lo[0]};
            end
            default: begin
                dec.hit  = j_full[1];
                dec.bits = {1'b0, j_full[0]};
            end
        endcase
    end

endmodule

// File: rtl/despread_tracker.sv
module despread_tracker
    import despread_pkg::*;
#(
    parameter int OSR       = 4,
    parameter int MAX_CHIPS = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       win_new,
    input  decision_t  dec,
    input  chip_mode_e mode,
    output logic       take,
    output logic       drop,
    output logic       corr_pulse
);
    localparam int CNT_W     = $clog2(OSR * MAX_CHIPS + 2);
    localparam int LONG_PER  = OSR * MAX_CHIPS;
    localparam int SHORT_PER = OSR * (MAX_CHIPS / 2);

    trk_state_e       state;
    logic [CNT_W-1:0] gap;
    logic [CNT_W-1:0] period;
    logic             in_win;

    assign period = (mode == MODE_SHORT || mode == MODE_PAIR) ?
                    CNT_W'(SHORT_PER) : CNT_W'(LONG_PER);

    assign in_win = (gap >= period - CNT_W'(1)) && (gap <= period + CNT_W'(1));

    always_comb begin
        take = win_new && dec.hit && ((state == TRK_SEARCH) || in_win);
        drop = win_new && (state == TRK_LOCKED) && !take &&
               (gap == period + CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= TRK_SEARCH;
            gap        <= '0;
            corr_pulse <= 1'b0;
        end else begin
            corr_pulse <= take;
            if (win_new) begin
                if (take) begin
                    state <= TRK_LOCKED;
                    gap   <= CNT_W'(1);
                end else if (drop) begin
                    state <= TRK_SEARCH;
                    gap   <= '0;
                end else if (state == TRK_LOCKED) begin
                    gap <= gap + CNT_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/despread_packer.sv
module despread_packer #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              pair,
    input  logic [1:0]        bits,
    input  logic              drop,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_valid
);
    localparam int FW = $clog2(BYTE_W + 1);

    logic [BYTE_W-1:0] acc, acc_n;
    logic [FW-1:0]     fill, fill_n;

    always_comb begin
        if (pair) begin
            acc_n  = {acc[BYTE_W-3:0], bits};
            fill_n = fill + FW'(2);
        end else begin
            acc_n  = {acc[BYTE_W-2:0], bits[0]};
            fill_n = fill + FW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc        <= '0;
            fill       <= '0;
            byte_data  <= '0;
            byte_valid <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            if (take) begin
                if (fill_n == FW'(BYTE_W)) begin
                    byte_data  <= acc_n;
                    byte_valid <= 1'b1;
                    acc        <= '0;
                    fill       <= '0;
                end else begin
                    acc  <= acc_n;
                    fill <= fill_n;
                end
            end else if (drop) begin
                acc  <= '0;
                fill <= '0;
            end
        end
    end

endmodule

// File: rtl/despread_correlator.sv
module despread_correlator
    import despread_pkg::*;
#(
    parameter int OSR       = 4,
    parameter int MAX_CHIPS = 64,
    parameter int BYTE_W    = 8,
    parameter int THR_W     = $clog2(MAX_CHIPS + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sample_valid,
    input  logic                 sample_in,
    input  logic [1:0]           mode,
    input  logic [MAX_CHIPS-1:0] pn_code,
    input  logic [THR_W-1:0]     threshold,
    output logic [BYTE_W-1:0]    byte_data,
    output logic                 byte_valid,
    output logic                 corr_valid
);
    chip_mode_e           mode_e;
    logic [MAX_CHIPS-1:0] chips;
    logic                 win_new;
    decision_t            dec;
    logic                 take, drop;

    assign mode_e = chip_mode_e'(mode);

    despread_window #(.OSR(OSR), .MAX_CHIPS(MAX_CHIPS)) u_window (
        .clk          (clk),
        .rst          (rst),
        .sample_valid (sample_valid),
        .sample_in    (sample_in),
        .chips        (chips),
        .win_new      (win_new)
    );

    despread_corr #(.MAX_CHIPS(MAX_CHIPS), .THR_W(THR_W)) u_corr (
        .chips (chips),
        .code  (pn_code),
        .thr   (threshold),
        .mode  (mode_e),
        .dec   (dec)
    );

    despread_tracker #(.OSR(OSR), .MAX_CHIPS(MAX_CHIPS)) u_tracker (
        .clk        (clk),
        .rst        (rst),
        .win_new    (win_new),
        .dec        (dec),
        .mode       (mode_e),
        .take       (take),
        .drop       (drop),
        .corr_pulse (corr_valid)
    );

    despread_packer #(.BYTE_W(BYTE_W)) u_packer (
        .clk        (clk),
        .rst        (rst),
        .take       (take),
        .pair       (dec.pair),
        .bits       (dec.bits),
        .drop       (drop),
        .byte_data  (byte_data),
        .byte_valid (byte_valid)
    );

endmodule

// File: rtl/despread_checker.sv
module despread_checker #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              sample_valid,
    input logic [BYTE_W-1:0] byte_data,
    input logic              byte_valid,
    input logic              corr_valid
);
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!byte_valid && !corr_valid));

    a_r9_byte_one_clock: assert property (@(posedge clk) disable iff (rst)
        byte_valid |=> !byte_valid);

    a_r9_byte_from_window: assert property (@(posedge clk) disable iff (rst)
        byte_valid |-> corr_valid);

    a_r9_data_holds: assert property (@(posedge clk) disable iff (rst)
        !$stable(byte_data) |-> byte_valid);

    a_r10_corr_one_clock: assert property (@(posedge clk) disable iff (rst)
        corr_valid |=> !corr_valid);

    a_r11_needs_sample: assert property (@(posedge clk) disable iff (rst)
        corr_valid |-> $past(sample_valid, 2));

endmodule

bind despread_correlator despread_checker #(.BYTE_W(BYTE_W)) u_checker (
    .clk          (clk),
    .rst          (rst),
    .sample_valid (sample_valid),
    .byte_data    (byte_data),
    .byte_valid   (byte_valid),
    .corr_valid   (corr_valid)
);

// File: tb/tb_despread_correlator.sv
module tb_despread_correlator;
    localparam int OSR = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sample_valid = 1'b0;
    logic        sample_in = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [63:0] code = 64'h9E37_79B9_6A09_E667;
    logic [6:0]  thr = 7'd56;
    logic [7:0]  byte_data;
    logic        byte_valid, corr_valid;

    int checks = 0;
    int fails = 0;
    int got_n = 0;
    int cv_n = 0;
    int gap_cycles = 0;
    logic [7:0] got [0:31];
    logic bv_prev = 1'b0;
    logic [15:0] lf = 16'hACE1;

    always #4 clk = ~clk;

    despread_correlator dut (
        .clk(clk), .rst(rst), .sample_valid(sample_valid), .sample_in(sample_in),
        .mode(mode), .pn_code(code), .threshold(thr),
        .byte_data(byte_data), .byte_valid(byte_valid), .corr_valid(corr_valid)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (byte_valid) begin
                chk(!bv_prev, "R9 strobe longer than one clock", 1, 0);
                if (got_n < 32) got[got_n] = byte_data;
                got_n++;
            end
            if (corr_valid) cv_n++;
            bv_prev = byte_valid;
        end else begin
            bv_prev = 1'b0;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        sample_valid = 1'b0;
        repeat (3) @(negedge clk);
        got_n = 0;
        cv_n = 0;
        rst = 1'b0;
    endtask

    task automatic put(input logic b);
        @(negedge clk);
        sample_valid = 1'b1;
        sample_in = b;
        for (int g = 0; g < gap_cycles; g++) begin
            @(negedge clk);
            sample_valid = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sample_valid = 1'b0;
            sample_in = 1'b0;
        end
    endtask

    // one symbol: len chips, code bit len-1 first; first `flips` chips inverted;
    // the first chip lasts first_len samples
    task automatic send_sym(input int len, input logic bh, input logic bl, input bit pr,
                            input int flips, input int first_len);
        for (int k = len - 1; k >= 0; k--) begin
            logic b;
            logic c;
            int n;
            b = (pr && k < len / 2) ? bl : bh;
            c = code[k] ^ ~b ^ ((len - 1 - k) < flips);
            n = (k == len - 1) ? first_len : OSR;
            for (int s = 0; s < n; s++) put(c);
        end
    endtask

    task automatic send_byte(input int len, input logic [7:0] d, input int flips);
        for (int i = 7; i >= 0; i--) send_sym(len, d[i], 1'b0, 1'b0, flips, OSR);
    endtask

    task automatic send_pair_byte(input logic [7:0] d, input int flips);
        for (int p = 3; p >= 0; p--) send_sym(32, d[2*p+1], d[2*p], 1'b1, flips, OSR);
    endtask

    task automatic expect_bytes(input string req, input int n,
                                input logic [7:0] e0, input logic [7:0] e1,
                                input logic [7:0] e2, input logic [7:0] e3);
        logic [7:0] e [0:3];
        e[0] = e0; e[1] = e1; e[2] = e2; e[3] = e3;
        chk(got_n == n, {req, " byte count"}, got_n, n);
        for (int i = 0; i < n && i < got_n; i++)
            chk(got[i] == e[i], {req, " byte value"}, got[i], e[i]);
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        #(150000 * 8);
        fails++;
        $display("FAIL watchdog: run did not complete");
        report();
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        chk(!byte_valid && !corr_valid && byte_data == 8'h00, "R1 reset outputs",
            {byte_data, byte_valid, corr_valid}, 0);

        // R10 / R6: window completes on first sample of its last chip
        mode = 2'd0; thr = 7'd56;
        do_reset();
        idle(10);
        for (int k = 63; k >= 1; k--)
            for (int s = 0; s < OSR; s++) put(code[k]);
        put(code[0]);
        @(negedge clk); sample_valid = 1'b0;
        chk(corr_valid == 1'b0, "R10 flag one clock early", corr_valid, 0);
        @(negedge clk);
        chk(corr_valid == 1'b1, "R6 R10 flag on second edge", corr_valid, 1);
        @(negedge clk);
        chk(corr_valid == 1'b0, "R10 flag one clock long", corr_valid, 0);

        // R2: long mode, clean stream
        do_reset();
        idle(8);
        send_byte(64, 8'hA5, 0); send_byte(64, 8'h3C, 0);
        send_byte(64, 8'h00, 0); send_byte(64, 8'hFF, 0);
        idle(3);
        chk(cv_n == 32, "R10 one flag per bit", cv_n, 32);
        idle(20);
        expect_bytes("R2 long mode", 4, 8'hA5, 8'h3C, 8'h00, 8'hFF);

        // R3: short mode
        mode = 2'd1; thr = 7'd28;
        do_reset();
        idle(8);
        send_byte(32, 8'h5A, 0); send_byte(32, 8'hC3, 0); send_byte(32, 8'h81, 0);
        idle(20);
        expect_bytes("R3 short mode", 3, 8'h5A, 8'hC3, 8'h81, 8'h00);

        // R4: paired mode
        mode = 2'd2; thr = 7'd28;
        do_reset();
        idle(8);
        send_pair_byte(8'h1E, 0); send_pair_byte(8'hB4, 0); send_pair_byte(8'h69, 0);
        idle(20);
        expect_bytes("R4 paired mode", 3, 8'h1E, 8'hB4, 8'h69, 8'h00);

        // R2 boundary: exactly threshold agreeing chips
        mode = 2'd0; thr = 7'd56;
        do_reset();
        idle(8);
        send_byte(64, 8'hC6, 8);
        idle(20);
        expect_bytes("R2 threshold met", 1, 8'hC6, 8'h00, 8'h00, 8'h00);

        // R5: one chip short of threshold
        do_reset();
        idle(8);
        send_byte(64, 8'hC6, 9);
        idle(20);
        chk(got_n == 0, "R5 below threshold bytes", got_n, 0);
        chk(cv_n == 0, "R5 below threshold flags", cv_n, 0);

        // R4 boundary: half threshold 14 of 16
        mode = 2'd2; thr = 7'd28;
        do_reset();
        idle(8);
        send_pair_byte(8'h4B, 2);
        idle(20);
        expect_bytes("R4 half threshold met", 1, 8'h4B, 8'h00, 8'h00, 8'h00);
        do_reset();
        idle(8);
        send_pair_byte(8'h4B, 3);
        idle(20);
        chk(got_n == 0, "R4 R5 one half short bytes", got_n, 0);
        chk(cv_n == 0, "R4 R5 one half short flags", cv_n, 0);

        // R5: random sample noise
        mode = 2'd0; thr = 7'd56;
        do_reset();
        for (int i = 0; i < 2000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            put(lf[0]);
        end
        idle(5);
        chk(got_n == 0, "R5 noise bytes", got_n, 0);
        chk(cv_n == 0, "R5 noise flags", cv_n, 0);

        // R7: one-sample slip each way, and a two-sample advance
        do_reset();
        idle(8);
        send_byte(64, 8'h96, 0);
        for (int i = 7; i >= 0; i--)
            send_sym(64, 1'(8'h4D >> i), 1'b0, 1'b0, 0, (i == 5) ? 5 : (i == 2) ? 3 : OSR);
        for (int i = 7; i >= 0; i--)
            send_sym(64, 1'(8'h2B >> i), 1'b0, 1'b0, 0, (i == 4) ? 2 : OSR);
        idle(20);
        expect_bytes("R7 tracking slack", 3, 8'h96, 8'h4D, 8'h2B, 8'h00);

        // R8: two-sample slip loses lock and restarts assembly
        do_reset();
        idle(8);
        for (int i = 7; i >= 0; i--)
            send_sym(64, 1'(8'hF0 >> i), 1'b0, 1'b0, 0, (i == 3) ? 6 : OSR);
        send_byte(64, 8'h33, 0);
        send_byte(64, 8'hAA, 0);
        idle(20);
        expect_bytes("R8 lock loss", 2, 8'h03, 8'h3A, 8'h00, 8'h00);

        // R11: idle clocks between samples
        mode = 2'd1; thr = 7'd28;
        do_reset();
        gap_cycles = 2;
        idle(8);
        send_byte(32, 8'h77, 0); send_byte(32, 8'h18, 0);
        gap_cycles = 0;
        idle(20);
        expect_bytes("R11 sparse samples", 2, 8'h77, 8'h18, 8'h00, 8'h00);

        report();
        $finish;
    end

endmodule